// File: doc/BRIEF.md
# Test Access Port with Reduced Instruction Set

This block is the serial test port for a memory device. A 16-state controller runs on the rising edge of the test clock and is steered by the mode-select line. It selects one of four shift paths between the serial input and the serial output: a 3-bit instruction register, a 1-bit pass-through register, a 32-bit identification register and a boundary register. The boundary register's length is a parameter, 107 by default. The boundary register takes a snapshot of the device pins. Two of the instructions also drive a line that tells the memory's data drivers to go to high impedance.

There is no test-reset pin. An active-low power-on reset puts the controller into Test-Logic-Reset. Holding the mode-select line high for five rising clock edges also reaches that state from anywhere. In both cases the identification instruction becomes the current instruction.

The serial output and its enable change only on the falling edge of the clock. Everything else is sampled on the rising edge.

Top module: `tap_core`

## Requirements
- R1: While `por_n` is low, the controller is in Test-Logic-Reset, the current instruction is IDCODE (001), `tdo_oe_o` is 0 and `out_hiz_o` is 0. A data scan made right after reset returns the identification word.
- R2: Five consecutive rising edges with `tms_i` high bring the controller to Test-Logic-Reset from any state. While the controller stays in Test-Logic-Reset, the current instruction becomes 001 by the next rising edge.
- R3: `tdo_oe_o` is 1 only while the controller is in Shift-IR or Shift-DR. `tdo_o` and `tdo_oe_o` change on the falling edge of `tck`, never on the rising edge.
- R4: Capture-IR loads the pattern 001 into the instruction shift stage. Bits leave least-significant first, so the output order is 1, 0, 0.
- R5: A shifted instruction takes effect only at the rising edge that leaves Update-IR. Before that edge, `out_hiz_o` keeps the value set by the previous instruction.
- R6: The opcodes select these data registers: 001 selects identification; 000, 010 and 100 select boundary; 111 selects pass-through. The unassigned codes 011, 101 and 110 also select pass-through.
- R7: The pass-through register captures 0 in Capture-DR. In Shift-DR it delays the serial input by exactly one clock.
- R8: The identification word is {revision[3:0], part[15:0], vendor 11'b00000010000, 1'b1}, shifted out starting at bit 0.
- R9: With a boundary opcode current, Capture-DR loads `pin_vals_i` into the boundary register. Bit 0 is shifted out first, and serial-input data reappears after exactly `BSR_LEN` shifts.
- R10: `out_hiz_o` is 1 exactly when the current opcode is 000 or 010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms_i | input | 1 | Mode select, sampled on the rising edge; board pull-up required |
| tdi_i | input | 1 | Serial data in, sampled on the rising edge; board pull-up required |
| pin_vals_i | input | BSR_LEN | Pin levels captured into the boundary register, bit 0 nearest the output |
| tdo_o | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe_o | output | 1 | Output enable for the serial data pad |
| out_hiz_o | output | 1 | Forces the memory data drivers to high impedance |

## Verification
A controller in the wrong state shows up at the ports at the very next falling edge. The output enable rises or falls one half-cycle early or late, or the bits of a scan come out shifted by one position. A wrong current instruction is visible at once on `out_hiz_o`. It also shows on the next data scan, which returns a wrong length, the wrong captured value (0, the identification word or the pin snapshot), or the wrong delay between input and output. A boundary or identification register that captures or shifts incorrectly is exposed within one full scan of `BSR_LEN` plus a few bits.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        TS_RESET  = 4'd0,
        TS_IDLE   = 4'd1,
        TS_SEL_DR = 4'd2,
        TS_CAP_DR = 4'd3,
        TS_SHF_DR = 4'd4,
        TS_EX1_DR = 4'd5,
        TS_PAU_DR = 4'd6,
        TS_EX2_DR = 4'd7,
        TS_UPD_DR = 4'd8,
        TS_SEL_IR = 4'd9,
        TS_CAP_IR = 4'd10,
        TS_SHF_IR = 4'd11,
        TS_EX1_IR = 4'd12,
        TS_PAU_IR = 4'd13,
        TS_EX2_IR = 4'd14,
        TS_UPD_IR = 4'd15
    } tap_state_e;

    typedef enum logic [1:0] {
        DRS_BYP = 2'd0,
        DRS_ID  = 2'd1,
        DRS_BND = 2'd2
    } dr_sel_e;

    localparam logic [IR_W-1:0] OP_HIZ_SAMPLE = 3'b000;
    localparam logic [IR_W-1:0] OP_IDENT      = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLE_Z   = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE     = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS     = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE    = 3'b001;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms_i,
    output tap_state_e state_o
);

    tap_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_RESET:  state_d = tms_i ? TS_RESET  : TS_IDLE;
            TS_IDLE:   state_d = tms_i ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: state_d = tms_i ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: state_d = tms_i ? TS_EX1_DR : TS_SHF_DR;
            TS_SHF_DR: state_d = tms_i ? TS_EX1_DR : TS_SHF_DR;
            TS_EX1_DR: state_d = tms_i ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: state_d = tms_i ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: state_d = tms_i ? TS_UPD_DR : TS_SHF_DR;
            TS_UPD_DR: state_d = tms_i ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: state_d = tms_i ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: state_d = tms_i ? TS_EX1_IR : TS_SHF_IR;
            TS_SHF_IR: state_d = tms_i ? TS_EX1_IR : TS_SHF_IR;
            TS_EX1_IR: state_d = tms_i ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: state_d = tms_i ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: state_d = tms_i ? TS_UPD_IR : TS_SHF_IR;
            TS_UPD_IR: state_d = tms_i ? TS_SEL_DR : TS_IDLE;
            default:   state_d = TS_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) state_q <= TS_RESET;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            por_n,
    input  logic            tdi_i,
    input  tap_state_e      state_i,
    output logic [IR_W-1:0] ir_cur_o,
    output logic [IR_W-1:0] ir_shift_o,
    output dr_sel_e         dr_sel_o,
    output logic            hiz_o
);

    typedef struct packed {
        logic [IR_W-1:0] shf;
        logic [IR_W-1:0] cur;
    } ir_regs_t;

    ir_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (state_i)
            TS_RESET:  r_d.cur = OP_IDENT;
            TS_CAP_IR: r_d.shf = IR_CAPTURE;
            TS_SHF_IR: r_d.shf = {tdi_i, r_q.shf[IR_W-1:1]};
            TS_UPD_IR: r_d.cur = r_q.shf;
            default:   r_d = r_q;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            r_q.shf <= IR_CAPTURE;
            r_q.cur <= OP_IDENT;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.cur)
            OP_IDENT:                            dr_sel_o = DRS_ID;
            OP_HIZ_SAMPLE, OP_SAMPLE_Z, OP_SAMPLE: dr_sel_o = DRS_BND;
            default:                             dr_sel_o = DRS_BYP;
        endcase
    end

    assign hiz_o      = (r_q.cur == OP_HIZ_SAMPLE) || (r_q.cur == OP_SAMPLE_Z);
    assign ir_cur_o   = r_q.cur;
    assign ir_shift_o = r_q.shf;

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int          BSR_LEN  = 107,
    parameter logic [31:0] ID_VALUE = 32'h0000_0021
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tdi_i,
    input  tap_state_e         state_i,
    input  dr_sel_e            dr_sel_i,
    input  logic [BSR_LEN-1:0] pin_vals_i,
    output logic               dr_out_o,
    output logic               byp_o
);

    localparam int ID_W = 32;

    typedef struct packed {
        logic               byp;
        logic [ID_W-1:0]    id;
        logic [BSR_LEN-1:0] bnd;
    } dr_regs_t;

    dr_regs_t r_d, r_q;
    logic [BSR_LEN-1:0] bnd_shifted;

    generate
        if (BSR_LEN > 1) begin : g_bnd_long
            assign bnd_shifted = {tdi_i, r_q.bnd[BSR_LEN-1:1]};
        end else begin : g_bnd_one
            assign bnd_shifted = tdi_i;
        end
    endgenerate

    always_comb begin
        r_d = r_q;
        if (state_i == TS_CAP_DR) begin
            unique case (dr_sel_i)
                DRS_ID:  r_d.id  = ID_VALUE;
                DRS_BND: r_d.bnd = pin_vals_i;
                default: r_d.byp = 1'b0;
            endcase
        end else if (state_i == TS_SHF_DR) begin
            unique case (dr_sel_i)
                DRS_ID:  r_d.id  = {tdi_i, r_q.id[ID_W-1:1]};
                DRS_BND: r_d.bnd = bnd_shifted;
                default: r_d.byp = tdi_i;
            endcase
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            r_q.byp <= 1'b0;
            r_q.id  <= ID_VALUE;
            r_q.bnd <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (dr_sel_i)
            DRS_ID:  dr_out_o = r_q.id[0];
            DRS_BND: dr_out_o = r_q.bnd[0];
            default: dr_out_o = r_q.byp;
        endcase
    end

    assign byp_o = r_q.byp;

endmodule

// File: rtl/tap_core.sv
module tap_core
    import tap_pkg::*;
#(
    parameter int          BSR_LEN   = 107,
    parameter logic [3:0]  ID_REV    = 4'h0,
    parameter logic [15:0] ID_PART   = 16'h0A5C,
    parameter logic [10:0] ID_VENDOR = 11'b00000010000
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tms_i,
    input  logic               tdi_i,
    input  logic [BSR_LEN-1:0] pin_vals_i,
    output logic               tdo_o,
    output logic               tdo_oe_o,
    output logic               out_hiz_o
);

    localparam logic [31:0] ID_VALUE = {ID_REV, ID_PART, ID_VENDOR, 1'b1};

    tap_state_e      fsm_state;
    logic [IR_W-1:0] ir_cur;
    logic [IR_W-1:0] ir_shift;
    dr_sel_e         dr_sel;
    logic            dr_out;
    logic            byp_bit;

    tap_fsm u_fsm (
        .tck     (tck),
        .por_n   (por_n),
        .tms_i   (tms_i),
        .state_o (fsm_state)
    );

    tap_ir u_ir (
        .tck        (tck),
        .por_n      (por_n),
        .tdi_i      (tdi_i),
        .state_i    (fsm_state),
        .ir_cur_o   (ir_cur),
        .ir_shift_o (ir_shift),
        .dr_sel_o   (dr_sel),
        .hiz_o      (out_hiz_o)
    );

    tap_dr #(
        .BSR_LEN  (BSR_LEN),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck        (tck),
        .por_n      (por_n),
        .tdi_i      (tdi_i),
        .state_i    (fsm_state),
        .dr_sel_i   (dr_sel),
        .pin_vals_i (pin_vals_i),
        .dr_out_o   (dr_out),
        .byp_o      (byp_bit)
    );

    typedef struct packed {
        logic tdo;
        logic oe;
    } out_regs_t;

    out_regs_t o_d, o_q;

    always_comb begin
        o_d     = o_q;
        o_d.oe  = (fsm_state == TS_SHF_DR) || (fsm_state == TS_SHF_IR);
        o_d.tdo = (fsm_state == TS_SHF_IR) ? ir_shift[0] : dr_out;
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign tdo_o    = o_q.tdo;
    assign tdo_oe_o = o_q.oe;

endmodule

// File: rtl/tap_core_chk.sv
module tap_core_chk
    import tap_pkg::*;
(
    input logic            tck,
    input logic            por_n,
    input logic            tms_i,
    input logic            tdo_oe_o,
    input logic            out_hiz_o,
    input tap_state_e      state_q,
    input logic [IR_W-1:0] ir_q,
    input logic [IR_W-1:0] ir_sr_q,
    input logic            byp_q,
    input dr_sel_e         dr_sel
);

    logic [2:0] ones_q;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)     ones_q <= 3'd0;
        else if (tms_i) ones_q <= (ones_q == 3'd5) ? 3'd5 : ones_q + 3'd1;
        else            ones_q <= 3'd0;
    end

    p_five_high_reset_r2: assert property (@(posedge tck) disable iff (!por_n)
        (ones_q >= 3'd5) |-> (state_q == TS_RESET));

    p_oe_shift_only_r3: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe_o == ((state_q == TS_SHF_DR) || (state_q == TS_SHF_IR)));

    p_ir_capture_r4: assert property (@(posedge tck) disable iff (!por_n)
        (state_q == TS_CAP_IR) |=> (ir_sr_q == 3'b001));

    p_ir_update_only_r5: assert property (@(posedge tck) disable iff (!por_n)
        ((state_q != TS_UPD_IR) && (state_q != TS_RESET)) |=> $stable(ir_q));

    p_byp_capture_r7: assert property (@(posedge tck) disable iff (!por_n)
        ((state_q == TS_CAP_DR) && (dr_sel == DRS_BYP)) |=> (byp_q == 1'b0));

    p_hiz_rise_r10: assert property (@(posedge tck) disable iff (!por_n)
        $rose(out_hiz_o) |-> ($past(state_q) == TS_UPD_IR));

endmodule

bind tap_core tap_core_chk chk_i (
    .tck       (tck),
    .por_n     (por_n),
    .tms_i     (tms_i),
    .tdo_oe_o  (tdo_oe_o),
    .out_hiz_o (out_hiz_o),
    .state_q   (fsm_state),
    .ir_q      (ir_cur),
    .ir_sr_q   (ir_shift),
    .byp_q     (byp_bit),
    .dr_sel    (dr_sel)
);

// File: tb/tap_core_tb_top.sv
module tap_core_tb_top;

    localparam int          TCK_PERIOD = 20;
    localparam int          LEN        = 107;
    localparam logic [3:0]  REV        = 4'hA;
    localparam logic [15:0] PART       = 16'h3C51;
    localparam logic [31:0] EXP_ID     = {REV, PART, 11'b00000010000, 1'b1};

    logic           tck;
    logic           por_n;
    logic           tms;
    logic           tdi;
    logic [LEN-1:0] pins;
    logic           tdo;
    logic           tdo_oe;
    logic           out_hiz;

    int n_checks;
    int n_fail;
    logic tx_bits [256];
    logic rx_bits [256];

    tap_core #(
        .BSR_LEN (LEN),
        .ID_REV  (REV),
        .ID_PART (PART)
    ) dut_i (
        .tck        (tck),
        .por_n      (por_n),
        .tms_i      (tms),
        .tdi_i      (tdi),
        .pin_vals_i (pins),
        .tdo_o      (tdo),
        .tdo_oe_o   (tdo_oe),
        .out_hiz_o  (out_hiz)
    );

    initial begin
        tck = 1'b0;
        forever #(TCK_PERIOD / 2) tck = ~tck;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o);
        o   = tdo;
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic mv(input logic m);
        logic o;
        step(m, 1'b0, o);
    endtask

    task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
        logic o;
        mv(1); mv(1); mv(0); mv(0);
        for (int i = 0; i < 3; i++) begin
            step(i == 2, op[i], o);
            cap[i] = o;
        end
        mv(1); mv(0);
    endtask

    task automatic scan_dr(input int n);
        logic o;
        mv(1); mv(0); mv(0);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, tx_bits[i], o);
            rx_bits[i] = o;
        end
        mv(1); mv(0);
    endtask

    function automatic logic [31:0] rx_word();
        logic [31:0] w;
        for (int i = 0; i < 32; i++) w[i] = rx_bits[i];
        return w;
    endfunction

    function automatic logic [LEN-1:0] pin_pattern(input logic inv);
        logic [LEN-1:0] p;
        for (int i = 0; i < LEN; i++) p[i] = ((i % 3) == 0) ^ ((i % 5) == 1) ^ inv;
        return p;
    endfunction

    task automatic check_boundary(input string tag);
        int mism;
        mism = 0;
        for (int i = 0; i < LEN + 8; i++) tx_bits[i] = ((i * 5) % 7) > 2;
        scan_dr(LEN + 8);
        for (int i = 0; i < LEN; i++) if (rx_bits[i] !== pins[i]) mism++;
        chk({tag, " capture"}, mism, 0);
        mism = 0;
        for (int j = 0; j < 8; j++) if (rx_bits[LEN + j] !== tx_bits[j]) mism++;
        chk({tag, " length"}, mism, 0);
    endtask

    task automatic t_reset;
        chk("R1 oe low after reset", tdo_oe, 1'b0);
        chk("R1 hiz low after reset", out_hiz, 1'b0);
        mv(0);
        for (int i = 0; i < 32; i++) tx_bits[i] = 1'b0;
        scan_dr(32);
        chk("R1 R8 id after reset", rx_word(), EXP_ID);
    endtask

    task automatic t_ir_capture;
        logic [2:0] cap;
        load_ir(3'b111, cap);
        chk("R4 capture-ir pattern", cap, 3'b001);
    endtask

    task automatic t_bypass;
        logic [9:0] pat, got, exp;
        pat = 10'b1011001110;
        for (int i = 0; i < 10; i++) tx_bits[i] = pat[i];
        scan_dr(10);
        for (int i = 0; i < 10; i++) got[i] = rx_bits[i];
        exp = {pat[8:0], 1'b0};
        chk("R7 R6 bypass delay", got, exp);
        chk("R10 bypass no hiz", out_hiz, 1'b0);
    endtask

    task automatic t_reserved;
        logic [2:0] cap;
        logic [2:0] codes [3];
        codes[0] = 3'b011; codes[1] = 3'b101; codes[2] = 3'b110;
        for (int k = 0; k < 3; k++) begin
            load_ir(codes[k], cap);
            chk("R10 reserved no hiz", out_hiz, 1'b0);
            tx_bits[0] = 1'b1; tx_bits[1] = 1'b0; tx_bits[2] = 1'b1; tx_bits[3] = 1'b1;
            scan_dr(4);
            chk("R6 reserved selects bypass",
                {rx_bits[0], rx_bits[1], rx_bits[2], rx_bits[3]}, 4'b0101);
        end
    endtask

    task automatic t_sample;
        logic [2:0] cap;
        pins = pin_pattern(1'b0);
        load_ir(3'b100, cap);
        chk("R10 sample no hiz", out_hiz, 1'b0);
        check_boundary("R9 sample");
    endtask

    task automatic t_sample_z;
        logic [2:0] cap;
        pins = pin_pattern(1'b1);
        load_ir(3'b010, cap);
        chk("R10 sample-z hiz", out_hiz, 1'b1);
        check_boundary("R9 sample-z");
    endtask

    task automatic t_zero_op;
        logic [2:0] cap;
        pins = pin_pattern(1'b0) ^ {LEN{1'b1}} ^ {{(LEN-1){1'b0}}, 1'b1};
        load_ir(3'b000, cap);
        chk("R10 opcode 000 hiz", out_hiz, 1'b1);
        check_boundary("R9 opcode 000");
    endtask

    task automatic t_tlr;
        logic [2:0] cap;
        load_ir(3'b010, cap);
        chk("R2 precondition hiz", out_hiz, 1'b1);
        mv(1); mv(0); mv(0);
        for (int i = 0; i < 5; i++) mv(1);
        mv(1);
        chk("R2 idcode back after five ones", out_hiz, 1'b0);
        mv(0);
        for (int i = 0; i < 32; i++) tx_bits[i] = 1'b1;
        scan_dr(32);
        chk("R2 R8 id after reset state", rx_word(), EXP_ID);
    endtask

    task automatic t_update_timing;
        logic o;
        mv(1); mv(1); mv(0); mv(0);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b1, o);
        step(1'b1, 1'b0, o);
        chk("R5 no change in exit1-ir", out_hiz, 1'b0);
        mv(1);
        chk("R5 no change in update-ir", out_hiz, 1'b0);
        mv(0);
        chk("R5 new opcode after update", out_hiz, 1'b1);
    endtask

    task automatic t_oe;
        mv(1); mv(0);
        chk("R3 oe low in capture-dr", tdo_oe, 1'b0);
        tms = 1'b0;
        @(posedge tck);
        #1;
        chk("R3 oe not on rising edge", tdo_oe, 1'b0);
        @(negedge tck);
        #1;
        chk("R3 oe on falling edge in shift-dr", tdo_oe, 1'b1);
        mv(1);
        chk("R3 oe low in exit1-dr", tdo_oe, 1'b0);
        mv(0);
        chk("R3 oe low in pause-dr", tdo_oe, 1'b0);
        mv(1); mv(1); mv(0);
        chk("R3 oe low in idle", tdo_oe, 1'b0);
    endtask

    initial begin
        n_checks = 0;
        n_fail   = 0;
        por_n    = 1'b0;
        tms      = 1'b1;
        tdi      = 1'b1;
        pins     = '0;
        repeat (3) @(negedge tck);
        #1;
        por_n = 1'b1;
        t_reset();
        t_ir_capture();
        t_bypass();
        t_reserved();
        t_sample();
        t_sample_z();
        t_zero_op();
        t_tlr();
        t_update_timing();
        t_oe();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(TCK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule